// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block tracks the coherence state of every line of one small direct-mapped cache on a snooping shared bus. A processor request is served locally when the line's state already grants the needed permission. Otherwise the controller stalls the processor, writes back a dirty victim if there is one, and issues a bus read or a read-for-ownership. While it does this, it watches bus traffic from the other caches. For each snooped transaction it gives a same-cycle shared response, asks for a flush of dirty data, and downgrades or invalidates its own copy.

A line can be Invalid, Shared, Exclusive (clean, sole copy) or Modified. A bus read fill lands in Exclusive or Shared according to the bus shared signal at fill time. Because of this, data that only one cache uses can later be written without any bus transaction. Only one miss can be outstanding at a time. Bus arbitration, the data array and memory sit outside this block.

Line address = `{tag, index}`, with the index in the low `IDX_W` bits. Bus command codes: READ = 0, RFO (read-for-ownership) = 1, WB (writeback) = 2.

Top module: `mesi_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus request is raised, `cpu_ready` is low, and snoops get no shared response.
- R2: A processor read that misses issues one READ (code 0) to the requested line address. At the cycle of `bus_ack` the line fills as Shared if `bus_shared` is high and as Exclusive if it is low, and `cpu_ready` is high in that same cycle.
- R3: A read hit in S, E or M, and a write hit in E or M, complete with `cpu_ready` in the request's first cycle and cause no bus transaction. A write to an Exclusive line makes it Modified.
- R4: A write to a line that is Shared or absent issues one RFO (code 1) to the line address. At the ack the line becomes Modified.
- R5: A miss whose victim is Modified under a different tag first issues WB (code 2) to the victim's address and then the fill request. A clean victim is dropped with no bus transaction and no longer answers snoops.
- R6: A snooped READ or RFO that hits a valid line raises `snp_shared` combinationally in that cycle. A snooped READ moves M to S with `snp_flush` high, moves E to S without a flush, and leaves S in S.
- R7: A snooped RFO moves M to I with `snp_flush` high, and moves E or S to I without a flush.
- R8: A snooped WB, or a snoop whose tag does not match, leaves the line state unchanged and raises no flush.
- R9: A snoop to the same index as a pending processor request in the same cycle is applied first. The processor request is stalled for that cycle and is then judged against the updated state.
- R10: While `bus_req_valid` is high without `bus_ack`, the command and address hold stable. At most one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request pending; held until `cpu_ready` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_ready | output | 1 | Request completes in this cycle |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 0 READ, 1 RFO, 2 WB |
| bus_req_addr | output | ADDR_W | Line address of the transaction |
| bus_ack | input | 1 | Current bus transaction completes this cycle |
| bus_shared | input | 1 | Another cache holds the line; sampled with `bus_ack` on a READ |
| snp_valid | input | 1 | Transaction from another cache seen on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_req_cmd` |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | Local valid copy exists (combinational) |
| snp_flush | output | 1 | Local copy is dirty and is supplied/written back (combinational) |

## Verification
The snoop responses and the hit completions depend only on inputs and the state table, so they are due in the same cycle as the stimulus. The bench samples them a moment after driving the inputs at the falling edge. A miss raises its first bus request one clock after the request; each request completes in the cycle the bench acknowledges it; `cpu_ready` comes with the final acknowledge. The bench therefore walks the request cycle by cycle and records each command and address. Every state change takes effect at the next rising edge, and a later snoop, sampled a full cycle later, exposes it through `snp_shared` and `snp_flush`.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_READ = 2'd0,
    BC_RFO  = 2'd1,
    BC_WB   = 2'd2,
    BC_NONE = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WB   = 2'd1,
    SQ_FILL = 2'd2
  } seq_st_e;
endpackage

// File: rtl/mesi_line_table.sv
module mesi_line_table
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cpu_idx,
  output line_st_e         cpu_st,
  output logic [TAG_W-1:0] cpu_tag,
  input  logic [IDX_W-1:0] snp_idx,
  output line_st_e         snp_st,
  output logic [TAG_W-1:0] snp_tag,
  input  logic             pri_we,
  input  line_st_e         pri_st,
  input  logic [TAG_W-1:0] pri_tag,
  input  logic             sec_we,
  input  line_st_e         sec_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_e         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic     pri_hit, sec_hit;
    line_st_e st_d;
    logic [TAG_W-1:0] tag_d;

    assign pri_hit = pri_we && (cpu_idx == IDX_W'(i));
    assign sec_hit = sec_we && (snp_idx == IDX_W'(i));

    always_comb begin
      st_d  = st_q[i];
      tag_d = tag_q[i];
      if (pri_hit) begin
        st_d  = pri_st;
        tag_d = pri_tag;
      end else if (sec_hit) begin
        st_d  = sec_st;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end else if (pri_hit || sec_hit) begin
        st_q[i]  <= st_d;
        tag_q[i] <= tag_d;
      end
    end
  end

  assign cpu_st  = st_q[cpu_idx];
  assign cpu_tag = tag_q[cpu_idx];
  assign snp_st  = st_q[snp_idx];
  assign snp_tag = tag_q[snp_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic             snp_valid,
  input  bus_cmd_e         snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_e         line_st,
  input  logic [TAG_W-1:0] line_tag,
  output logic             shared,
  output logic             flush,
  output logic             upd_we,
  output line_st_e         upd_st
);
  logic hit;
  assign hit    = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
  assign shared = hit;

  always_comb begin
    flush  = 1'b0;
    upd_we = 1'b0;
    upd_st = line_st;
    if (hit) begin
      unique case (snp_cmd)
        BC_READ: begin
          flush  = (line_st == ST_M);
          upd_we = 1'b1;
          upd_st = ST_S;
        end
        BC_RFO: begin
          flush  = (line_st == ST_M);
          upd_we = 1'b1;
          upd_st = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_miss_seq.sv
module mesi_miss_seq
  import mesi_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic             cpu_write,
  input  logic [TAG_W-1:0] cpu_tag,
  input  line_st_e         line_st,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             conflict,
  input  logic             bus_ack,
  input  logic             bus_shared,
  output logic             cpu_ready,
  output logic             req_valid,
  output bus_cmd_e         req_cmd,
  output logic [TAG_W-1:0] req_tag,
  output logic             tbl_we,
  output line_st_e         tbl_st,
  output logic [TAG_W-1:0] tbl_tag
);
  seq_st_e          seq_q, seq_d;
  bus_cmd_e         cmd_q, cmd_d;
  logic [TAG_W-1:0] vtag_q, vtag_d;
  logic             hit, perm;

  assign hit  = (line_st != ST_I) && (line_tag == cpu_tag);
  assign perm = hit && (!cpu_write || line_st == ST_M || line_st == ST_E);

  always_comb begin
    seq_d     = seq_q;
    cmd_d     = cmd_q;
    vtag_d    = vtag_q;
    cpu_ready = 1'b0;
    tbl_we    = 1'b0;
    tbl_st    = line_st;
    tbl_tag   = line_tag;
    unique case (seq_q)
      SQ_IDLE: begin
        if (cpu_valid && !conflict) begin
          if (perm) begin
            cpu_ready = 1'b1;
            tbl_we    = cpu_write && (line_st == ST_E);
            tbl_st    = ST_M;
          end else begin
            cmd_d  = cpu_write ? BC_RFO : BC_READ;
            vtag_d = line_tag;
            seq_d  = (!hit && line_st == ST_M) ? SQ_WB : SQ_FILL;
          end
        end
      end
      SQ_WB: begin
        if (bus_ack) begin
          tbl_we = 1'b1;
          tbl_st = ST_I;
          seq_d  = SQ_FILL;
        end
      end
      SQ_FILL: begin
        if (bus_ack) begin
          cpu_ready = 1'b1;
          tbl_we    = 1'b1;
          tbl_tag   = cpu_tag;
          tbl_st    = (cmd_q == BC_RFO) ? ST_M : (bus_shared ? ST_S : ST_E);
          seq_d     = SQ_IDLE;
        end
      end
      default: seq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SQ_IDLE;
      cmd_q  <= BC_READ;
      vtag_q <= '0;
    end else begin
      seq_q  <= seq_d;
      cmd_q  <= cmd_d;
      vtag_q <= vtag_d;
    end
  end

  assign req_valid = (seq_q != SQ_IDLE);
  assign req_cmd   = (seq_q == SQ_WB) ? BC_WB : cmd_q;
  assign req_tag   = (seq_q == SQ_WB) ? vtag_q : cpu_tag;
endmodule

// File: rtl/mesi_coherence_ctrl.sv
module mesi_coherence_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_ack,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  line_st_e         cl_st, sl_st, pri_st, sec_st;
  logic [TAG_W-1:0] cl_tag, sl_tag, pri_tag, req_tag;
  logic             pri_we, sec_we, conflict;
  bus_cmd_e         req_cmd;

  assign conflict = snp_valid && (snp_idx == cpu_idx);

  mesi_line_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst_n(rst_int_n),
    .cpu_idx(cpu_idx), .cpu_st(cl_st), .cpu_tag(cl_tag),
    .snp_idx(snp_idx), .snp_st(sl_st), .snp_tag(sl_tag),
    .pri_we(pri_we), .pri_st(pri_st), .pri_tag(pri_tag),
    .sec_we(sec_we), .sec_st(sec_st)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid(snp_valid && rst_int_n), .snp_cmd(bus_cmd_e'(snp_cmd)),
    .snp_tag(snp_tag), .line_st(sl_st), .line_tag(sl_tag),
    .shared(snp_shared), .flush(snp_flush),
    .upd_we(sec_we), .upd_st(sec_st)
  );

  mesi_miss_seq #(.TAG_W(TAG_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .cpu_valid(cpu_valid && rst_int_n), .cpu_write(cpu_write),
    .cpu_tag(cpu_tag), .line_st(cl_st), .line_tag(cl_tag),
    .conflict(conflict), .bus_ack(bus_ack), .bus_shared(bus_shared),
    .cpu_ready(cpu_ready), .req_valid(bus_req_valid), .req_cmd(req_cmd),
    .req_tag(req_tag), .tbl_we(pri_we), .tbl_st(pri_st), .tbl_tag(pri_tag)
  );

  assign bus_req_cmd  = req_cmd;
  assign bus_req_addr = {req_tag, cpu_idx};
endmodule

// File: rtl/mesi_coherence_chk.sv
module mesi_coherence_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              bus_req_valid,
  input logic [1:0]        bus_req_cmd,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              bus_ack,
  input logic              snp_shared,
  input logic              snp_flush
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_ack |=> bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr));

  // R5
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_cmd == 2'd2 && bus_ack |=> bus_req_valid && bus_req_cmd != 2'd2);

  // R6
  flush_with_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_shared);

  // R2
  ready_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && bus_req_valid |-> bus_ack && bus_req_cmd != 2'd2);

  // R3
  ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);
endmodule

bind mesi_coherence_ctrl mesi_coherence_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
  .bus_req_addr(bus_req_addr), .bus_ack(bus_ack),
  .snp_shared(snp_shared), .snp_flush(snp_flush)
);

// File: tb/test_mesi_coherence_ctrl.sv
`timescale 1ns/1ps
module test_mesi_coherence_ctrl;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic cpu_ready;
  logic bus_req_valid;
  logic [1:0] bus_req_cmd;
  logic [ADDR_W-1:0] bus_req_addr;
  logic bus_ack = 1'b0, bus_shared = 1'b0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'd0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic snp_shared, snp_flush;

  always #10 clk = ~clk;

  mesi_coherence_ctrl #(.ADDR_W(ADDR_W), .IDX_W(3)) i_mesi_coherence_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .bus_req_valid(bus_req_valid),
    .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr), .bus_ack(bus_ack),
    .bus_shared(bus_shared), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_shared(snp_shared), .snp_flush(snp_flush)
  );

  int n_run = 0, n_fail = 0, cycles = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // op: 0 cpu (cmd[0] = write), 1 snoop (cmd = bus code)
  typedef struct packed {
    logic       op;
    logic [1:0] cmd;
    logic [7:0] addr;
    logic       sh;
    logic [1:0] n;
    logic [1:0] c0;
    logic [1:0] c1;
    logic [7:0] a0;
    logic       ssh;
    logic       fl;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    {1'b0,2'd0,8'h08,1'b0,2'd1,2'd0,2'd0,8'h08,1'b0,1'b0}, // R2 read miss -> E
    {1'b1,2'd0,8'h08,1'b0,2'd0,2'd0,2'd0,8'h00,1'b1,1'b0}, // R6 E -> S
    {1'b0,2'd1,8'h08,1'b0,2'd1,2'd1,2'd0,8'h08,1'b0,1'b0}, // R4 S write -> RFO
    {1'b1,2'd0,8'h08,1'b0,2'd0,2'd0,2'd0,8'h00,1'b1,1'b1}, // R6 M -> S flush
    {1'b1,2'd1,8'h08,1'b0,2'd0,2'd0,2'd0,8'h00,1'b1,1'b0}, // R7 S -> I
    {1'b1,2'd0,8'h08,1'b0,2'd0,2'd0,2'd0,8'h00,1'b0,1'b0}, // R7 now invalid
    {1'b0,2'd0,8'h08,1'b1,2'd1,2'd0,2'd0,8'h08,1'b0,1'b0}, // R2 read miss -> S
    {1'b0,2'd0,8'h08,1'b0,2'd0,2'd0,2'd0,8'h00,1'b0,1'b0}, // R3 read hit
    {1'b1,2'd1,8'h08,1'b0,2'd0,2'd0,2'd0,8'h00,1'b1,1'b0}, // R7 S -> I
    {1'b0,2'd0,8'h09,1'b0,2'd1,2'd0,2'd0,8'h09,1'b0,1'b0}, // R2 -> E
    {1'b0,2'd1,8'h09,1'b0,2'd0,2'd0,2'd0,8'h00,1'b0,1'b0}, // R3 E write silent
    {1'b0,2'd1,8'h09,1'b0,2'd0,2'd0,2'd0,8'h00,1'b0,1'b0}, // R3 M write hit
    {1'b1,2'd2,8'h09,1'b0,2'd0,2'd0,2'd0,8'h00,1'b1,1'b0}, // R8 snoop WB no change
    {1'b1,2'd0,8'h09,1'b0,2'd0,2'd0,2'd0,8'h00,1'b1,1'b1}, // R6 still M -> S flush
    {1'b0,2'd1,8'h09,1'b0,2'd1,2'd1,2'd0,8'h09,1'b0,1'b0}, // R4 upgrade
    {1'b0,2'd0,8'h11,1'b0,2'd2,2'd2,2'd0,8'h09,1'b0,1'b0}, // R5 dirty victim WB
    {1'b1,2'd0,8'h09,1'b0,2'd0,2'd0,2'd0,8'h00,1'b0,1'b0}, // R5 victim gone
    {1'b1,2'd0,8'h11,1'b0,2'd0,2'd0,2'd0,8'h00,1'b1,1'b0}, // R6 E -> S
    {1'b1,2'd1,8'h11,1'b0,2'd0,2'd0,2'd0,8'h00,1'b1,1'b0}, // R7 S -> I
    {1'b0,2'd0,8'h11,1'b0,2'd1,2'd0,2'd0,8'h11,1'b0,1'b0}, // R2 -> E
    {1'b0,2'd1,8'h19,1'b0,2'd1,2'd1,2'd0,8'h19,1'b0,1'b0}, // R5 clean victim silent
    {1'b1,2'd0,8'h11,1'b0,2'd0,2'd0,2'd0,8'h00,1'b0,1'b0}, // R5 clean victim gone
    {1'b1,2'd1,8'h19,1'b0,2'd0,2'd0,2'd0,8'h00,1'b1,1'b1}, // R7 M -> I flush
    {1'b1,2'd0,8'h2A,1'b0,2'd0,2'd0,2'd0,8'h00,1'b0,1'b0}  // R8 tag miss
  };

  task automatic cpu_op(input logic wr, input logic [7:0] a, input logic sh,
                        output int n, output logic [1:0] c0, output logic [1:0] c1,
                        output logic [7:0] a0);
    bit done = 0;
    n = 0; c0 = 2'd3; c1 = 2'd3; a0 = '0;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a;
    for (int k = 0; k < 16 && !done; k++) begin
      #1;
      if (bus_req_valid) begin
        if (n == 0) begin c0 = bus_req_cmd; a0 = bus_req_addr; end
        else if (n == 1) c1 = bus_req_cmd;
        n++;
        bus_ack = 1'b1; bus_shared = sh;
      end
      #1 done = cpu_ready;
      @(posedge clk); #1;
      bus_ack = 1'b0; bus_shared = 1'b0;
      if (done) cpu_valid = 1'b0;
      else @(negedge clk);
    end
    cpu_valid = 1'b0;
    check("R10 request completes", 32'(done), 32'd1);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a,
                       output logic s, output logic f);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #1 s = snp_shared; f = snp_flush;
    @(posedge clk); #1 snp_valid = 1'b0;
  endtask

  initial begin
    int n; logic [1:0] c0, c1; logic [7:0] a0; logic s, f;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 no bus request", 32'(bus_req_valid), 32'd0);
    check("R1 no ready", 32'(cpu_ready), 32'd0);
    snoop(2'd0, 8'h08, s, f);
    check("R1 snoop shared", 32'(s), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op == 1'b0) begin
        cpu_op(VEC[i].cmd[0], VEC[i].addr, VEC[i].sh, n, c0, c1, a0);
        check($sformatf("R2-R5 vec%0d count", i), 32'(n), 32'(VEC[i].n));
        if (VEC[i].n > 0) begin
          check($sformatf("R2/R4/R5 vec%0d cmd0", i), 32'(c0), 32'(VEC[i].c0));
          check($sformatf("R5 vec%0d addr0", i), 32'(a0), 32'(VEC[i].a0));
        end
        if (VEC[i].n > 1)
          check($sformatf("R5 vec%0d cmd1", i), 32'(c1), 32'(VEC[i].c1));
      end else begin
        snoop(VEC[i].cmd, VEC[i].addr, s, f);
        check($sformatf("R6/R7/R8 vec%0d shared", i), 32'(s), 32'(VEC[i].ssh));
        check($sformatf("R6/R7/R8 vec%0d flush", i), 32'(f), 32'(VEC[i].fl));
      end
    end

    // R9: line 0x08 in E, write and snooped read in the same cycle
    cpu_op(1'b0, 8'h08, 1'b0, n, c0, c1, a0);
    check("R9 setup read", 32'(n), 32'd1);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = 8'h08;
    snp_valid = 1'b1; snp_cmd = 2'd0; snp_addr = 8'h08;
    #1;
    check("R9 cpu stalled", 32'(cpu_ready), 32'd0);
    check("R9 snoop shared", 32'(snp_shared), 32'd1);
    check("R9 snoop no flush", 32'(snp_flush), 32'd0);
    @(posedge clk); #1 snp_valid = 1'b0; cpu_valid = 1'b0;
    cpu_op(1'b1, 8'h08, 1'b0, n, c0, c1, a0);
    check("R9 write now needs RFO", 32'(n), 32'd1);
    check("R9 RFO code", 32'(c0), 32'd1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule